// File: doc/BRIEF.md
# Shared-Then-Invalidate Coherence Traffic Generator

This block produces a fixed stress pattern for a cache-coherence fabric with N requester ports. For a single line address, every port reads the line one after another, so each cache holds a shared copy. One port then writes the line, which forces the other copies to be invalidated. The pattern repeats, and the writing port rotates by one on each repeat. When every port has written once, the address moves on by a fixed step.

Each port has a valid/ready request channel and a response channel. The address, the read/write kind and the write data are common to all ports, and only the valid bit is per port. Only one request is ever in flight. The block checks that every response arrives on the expected port and carries the current address. It counts completed writes and stops issuing requests once a target count is reached. All sizes and counts are parameters. Reset is synchronous and active high.

Top module: `shinv_traffic_gen`

## Requirements
- R1: After reset, exactly port 0 presents a read of address 0, and done_o and err_o are low.
- R2: At most one bit of req_valid_o is high at any time. Reads are issued from ports 0, 1, ..., N-1 in order, each with req_write_o = 0, and each is a single-byte access to req_addr_o.
- R3: While the presenting port's req_ready_i is low, the same valid bit, address and kind are presented again on every following cycle.
- R4: In the cycle after a request is accepted, no request is presented until its response has been received.
- R5: After the N-th read response, one write (req_write_o = 1, req_wdata_o = 0) is presented from the current write port. After that write's response, the read sequence restarts at port 0.
- R6: The write port advances by one after each write response, in the order 0, 1, ..., N-1, 0. After the write from port N-1 completes, req_addr_o increases by STEP (default 64).
- R7: Once TARGET write responses have been received, done_o is high and req_valid_o stays all-zero.
- R8: A response on a port other than the expected one, or on the expected port with an address other than req_addr_o, sets err_o and does not advance the sequence.
- R9: A response that arrives while no request is outstanding sets err_o and is otherwise ignored.
- R10: err_o stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_o | output | N | Per-port request valid (at most one high) |
| req_ready_i | input | N | Per-port request ready |
| req_write_o | output | 1 | 1 = write request, 0 = read request |
| req_addr_o | output | ADDR_W | Byte address of the single-byte request |
| req_wdata_o | output | 8 | Write data, always zero |
| rsp_valid_i | input | N | Per-port response valid |
| rsp_addr_i | input | N*ADDR_W | Per-port response address, port p in bits [p*ADDR_W +: ADDR_W] |
| done_o | output | 1 | Target number of writes completed |
| err_o | output | 1 | Sticky response-protocol error |

## Verification
A corrupted port index or phase shows up in the first cycle a request is next presented: the wrong valid bit, the wrong kind, or a wrong address appears on the request bus. That is at most one cycle after the response that moved the sequence. A miscounted write counter or a miscounted address step stays hidden until a round boundary or until the target is reached. The bench therefore follows the full request order, including the address step and the done point. A response filter that is too loose or too strict changes err_o on the cycle after the offending response, and it also changes whether the next request is presented.

// File: rtl/shinv_pkg.sv
package shinv_pkg;

    // Sequencer phases: waiting to issue or waiting for a response, for reads and writes
    typedef enum logic [1:0] {
        ST_RD_ISSUE = 2'd0,
        ST_RD_WAIT  = 2'd1,
        ST_WR_ISSUE = 2'd2,
        ST_WR_WAIT  = 2'd3
    } shinv_state_e;

    localparam int unsigned SHINV_DATA_W = 8;

endpackage

// File: rtl/shinv_port_sel.sv
// Expands a port index into a per-port one-hot valid vector, gated by an enable.
module shinv_port_sel #(
    parameter int unsigned N     = 4,
    localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             en,
    input  logic [IDX_W-1:0] idx,
    output logic [N-1:0]     onehot
);
    for (genvar p = 0; p < N; p++) begin : g_port
        assign onehot[p] = en && (idx == IDX_W'(p));
    end
endmodule

// File: rtl/shinv_rsp_check.sv
// Classifies the response inputs against the port and address that are expected.
module shinv_rsp_check #(
    parameter int unsigned N      = 4,
    parameter int unsigned ADDR_W = 16,
    localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic                pending,
    input  logic [IDX_W-1:0]    exp_idx,
    input  logic [ADDR_W-1:0]   exp_addr,
    input  logic [N-1:0]        rsp_valid,
    input  logic [N*ADDR_W-1:0] rsp_addr,
    output logic                hit,
    output logic                bad
);
    logic [N-1:0] sel;
    logic [N-1:0] addr_eq;

    for (genvar p = 0; p < N; p++) begin : g_cmp
        assign sel[p]     = (exp_idx == IDX_W'(p));
        assign addr_eq[p] = (rsp_addr[p*ADDR_W +: ADDR_W] == exp_addr);
    end

    logic stray;
    logic exp_vld;
    logic exp_ok;

    always_comb begin
        stray   = |(rsp_valid & ~sel);
        exp_vld = |(rsp_valid & sel);
        exp_ok  = |(rsp_valid & sel & addr_eq);
        if (pending) begin
            hit = exp_ok && !stray;
            bad = stray || (exp_vld && !exp_ok);
        end else begin
            hit = 1'b0;
            bad = |rsp_valid;
        end
    end
endmodule

// File: rtl/shinv_traffic_gen.sv
module shinv_traffic_gen
    import shinv_pkg::*;
#(
    parameter int unsigned N      = 4,
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned STEP   = 64,
    parameter int unsigned TARGET = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    output logic [N-1:0]            req_valid_o,
    input  logic [N-1:0]            req_ready_i,
    output logic                    req_write_o,
    output logic [ADDR_W-1:0]       req_addr_o,
    output logic [SHINV_DATA_W-1:0] req_wdata_o,
    input  logic [N-1:0]            rsp_valid_i,
    input  logic [N*ADDR_W-1:0]     rsp_addr_i,
    output logic                    done_o,
    output logic                    err_o
);
    localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1;
    localparam int unsigned CNT_W = $clog2(TARGET + 1);
    localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(N - 1);
    localparam logic [CNT_W-1:0]  GOAL     = CNT_W'(TARGET);
    localparam logic [ADDR_W-1:0] ADDR_INC = ADDR_W'(STEP);

    typedef struct packed {
        shinv_state_e      st;
        logic [IDX_W-1:0]  rd_idx;
        logic [IDX_W-1:0]  wr_idx;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  wr_cnt;
        logic              err;
    } seq_regs_t;

    localparam seq_regs_t SEQ_INIT = '{
        st:     ST_RD_ISSUE,
        rd_idx: '0,
        wr_idx: '0,
        addr:   '0,
        wr_cnt: '0,
        err:    1'b0
    };

    seq_regs_t seq_d, seq_q;

    logic             finished;
    logic             issuing;
    logic             awaiting;
    logic             read_phase;
    logic [IDX_W-1:0] cur_idx;
    logic             accepted;
    logic             rsp_hit;
    logic             rsp_bad;

    always_comb begin
        finished   = (seq_q.wr_cnt == GOAL);
        read_phase = (seq_q.st == ST_RD_ISSUE) || (seq_q.st == ST_RD_WAIT);
        issuing    = ((seq_q.st == ST_RD_ISSUE) || (seq_q.st == ST_WR_ISSUE)) && !finished;
        awaiting   = (seq_q.st == ST_RD_WAIT) || (seq_q.st == ST_WR_WAIT);
        cur_idx    = read_phase ? seq_q.rd_idx : seq_q.wr_idx;
    end

    shinv_port_sel #(.N(N)) u_port_sel (
        .en     (issuing),
        .idx    (cur_idx),
        .onehot (req_valid_o)
    );

    assign accepted = |(req_valid_o & req_ready_i);

    shinv_rsp_check #(.N(N), .ADDR_W(ADDR_W)) u_rsp_check (
        .pending   (awaiting),
        .exp_idx   (cur_idx),
        .exp_addr  (seq_q.addr),
        .rsp_valid (rsp_valid_i),
        .rsp_addr  (rsp_addr_i),
        .hit       (rsp_hit),
        .bad       (rsp_bad)
    );

    always_comb begin
        seq_d = seq_q;
        if (rsp_bad) begin
            seq_d.err = 1'b1;
        end
        unique case (seq_q.st)
            ST_RD_ISSUE: begin
                if (accepted) seq_d.st = ST_RD_WAIT;
            end
            ST_WR_ISSUE: begin
                if (accepted) seq_d.st = ST_WR_WAIT;
            end
            ST_RD_WAIT: begin
                if (rsp_hit) begin
                    if (seq_q.rd_idx == LAST_IDX) begin
                        seq_d.rd_idx = '0;
                        seq_d.st     = ST_WR_ISSUE;
                    end else begin
                        seq_d.rd_idx = seq_q.rd_idx + 1'b1;
                        seq_d.st     = ST_RD_ISSUE;
                    end
                end
            end
            ST_WR_WAIT: begin
                if (rsp_hit) begin
                    seq_d.wr_cnt = seq_q.wr_cnt + 1'b1;
                    seq_d.st     = ST_RD_ISSUE;
                    if (seq_q.wr_idx == LAST_IDX) begin
                        seq_d.wr_idx = '0;
                        seq_d.addr   = seq_q.addr + ADDR_INC;
                    end else begin
                        seq_d.wr_idx = seq_q.wr_idx + 1'b1;
                    end
                end
            end
            default: seq_d = SEQ_INIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q <= SEQ_INIT;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign req_write_o = !read_phase;
    assign req_addr_o  = seq_q.addr;
    assign req_wdata_o = '0;
    assign done_o      = finished;
    assign err_o       = seq_q.err;

endmodule

// File: rtl/shinv_traffic_gen_chk.sv
module shinv_traffic_gen_chk #(
    parameter int unsigned N      = 4,
    parameter int unsigned ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [N-1:0]      req_valid_o,
    input logic [N-1:0]      req_ready_i,
    input logic              req_write_o,
    input logic [ADDR_W-1:0] req_addr_o,
    input logic [N-1:0]      rsp_valid_i,
    input logic              done_o,
    input logic              err_o
);
    // R2: a single port drives a request at a time
    p_single_port_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(req_valid_o));

    // R3: a stalled request is repeated unchanged
    p_stall_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (|(req_valid_o & ~req_ready_i)) |=>
            (req_valid_o == $past(req_valid_o)) && $stable(req_addr_o) && $stable(req_write_o));

    // R4: nothing is presented right after an acceptance
    p_one_outstanding_r4: assert property (@(posedge clk) disable iff (rst)
        (|(req_valid_o & req_ready_i)) |=> (req_valid_o == '0));

    // R7: no traffic once the target is reached
    p_done_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (req_valid_o == '0));

    // R7: done stays asserted
    p_done_holds_r7: assert property (@(posedge clk) disable iff (rst)
        done_o |=> done_o);

    // R9: a response while a request is still being offered is an error
    p_early_rsp_r9: assert property (@(posedge clk) disable iff (rst)
        ((|rsp_valid_i) && (|req_valid_o)) |=> err_o);

    // R10: the error flag is sticky
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o);
endmodule

bind shinv_traffic_gen shinv_traffic_gen_chk #(.N(N), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid_o (req_valid_o),
    .req_ready_i (req_ready_i),
    .req_write_o (req_write_o),
    .req_addr_o  (req_addr_o),
    .rsp_valid_i (rsp_valid_i),
    .done_o      (done_o),
    .err_o       (err_o)
);

// File: tb/shinv_traffic_gen_tb.sv
module shinv_traffic_gen_tb_top;
    localparam int N      = 4;
    localparam int ADDR_W = 16;
    localparam int STEP   = 64;
    localparam int TARGET = 6;
    localparam int NVEC   = 30;

    // entry: [27:24] stall cycles, [23:20] expected port, [16] expected write, [15:0] expected address
    localparam logic [27:0] VEC [NVEC] = '{
        {4'd0, 4'd0, 3'd0, 1'b0, 16'h0000}, {4'd1, 4'd1, 3'd0, 1'b0, 16'h0000},
        {4'd0, 4'd2, 3'd0, 1'b0, 16'h0000}, {4'd2, 4'd3, 3'd0, 1'b0, 16'h0000},
        {4'd3, 4'd0, 3'd0, 1'b1, 16'h0000},
        {4'd0, 4'd0, 3'd0, 1'b0, 16'h0000}, {4'd0, 4'd1, 3'd0, 1'b0, 16'h0000},
        {4'd1, 4'd2, 3'd0, 1'b0, 16'h0000}, {4'd0, 4'd3, 3'd0, 1'b0, 16'h0000},
        {4'd0, 4'd1, 3'd0, 1'b1, 16'h0000},
        {4'd2, 4'd0, 3'd0, 1'b0, 16'h0000}, {4'd0, 4'd1, 3'd0, 1'b0, 16'h0000},
        {4'd0, 4'd2, 3'd0, 1'b0, 16'h0000}, {4'd1, 4'd3, 3'd0, 1'b0, 16'h0000},
        {4'd1, 4'd2, 3'd0, 1'b1, 16'h0000},
        {4'd0, 4'd0, 3'd0, 1'b0, 16'h0000}, {4'd3, 4'd1, 3'd0, 1'b0, 16'h0000},
        {4'd0, 4'd2, 3'd0, 1'b0, 16'h0000}, {4'd0, 4'd3, 3'd0, 1'b0, 16'h0000},
        {4'd0, 4'd3, 3'd0, 1'b1, 16'h0000},
        {4'd1, 4'd0, 3'd0, 1'b0, 16'h0040}, {4'd0, 4'd1, 3'd0, 1'b0, 16'h0040},
        {4'd2, 4'd2, 3'd0, 1'b0, 16'h0040}, {4'd0, 4'd3, 3'd0, 1'b0, 16'h0040},
        {4'd0, 4'd0, 3'd0, 1'b1, 16'h0040},
        {4'd0, 4'd0, 3'd0, 1'b0, 16'h0040}, {4'd1, 4'd1, 3'd0, 1'b0, 16'h0040},
        {4'd0, 4'd2, 3'd0, 1'b0, 16'h0040}, {4'd0, 4'd3, 3'd0, 1'b0, 16'h0040},
        {4'd2, 4'd1, 3'd0, 1'b1, 16'h0040}
    };

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [N-1:0]        req_valid_o;
    logic [N-1:0]        req_ready_i = '0;
    logic                req_write_o;
    logic [ADDR_W-1:0]   req_addr_o;
    logic [7:0]          req_wdata_o;
    logic [N-1:0]        rsp_valid_i = '0;
    logic [N*ADDR_W-1:0] rsp_addr_i = '0;
    logic                done_o;
    logic                err_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    shinv_traffic_gen #(.N(N), .ADDR_W(ADDR_W), .STEP(STEP), .TARGET(TARGET)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .req_valid_o (req_valid_o),
        .req_ready_i (req_ready_i),
        .req_write_o (req_write_o),
        .req_addr_o  (req_addr_o),
        .req_wdata_o (req_wdata_o),
        .rsp_valid_i (rsp_valid_i),
        .rsp_addr_i  (rsp_addr_i),
        .done_o      (done_o),
        .err_o       (err_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; req_ready_i = '0; rsp_valid_i = '0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // drive a single response on one port for one cycle, at a negedge
    task automatic respond(input int port, input logic [ADDR_W-1:0] addr);
        rsp_valid_i = '0;
        rsp_valid_i[port] = 1'b1;
        rsp_addr_i = '0;
        rsp_addr_i[port*ADDR_W +: ADDR_W] = addr;
        @(posedge clk);
        @(negedge clk);
        rsp_valid_i = '0;
    endtask

    task automatic walk_entry(input logic [27:0] v);
        int stall = int'(v[27:24]);
        int port  = int'(v[23:20]);
        logic [N-1:0] exp_v = N'(1) << port;
        req_ready_i = '0;
        for (int s = 0; s < stall; s++) begin
            @(posedge clk); @(negedge clk);
            check("R3 stalled valid", 32'(req_valid_o), 32'(exp_v));
            check("R3 stalled addr", 32'(req_addr_o), 32'(v[15:0]));
        end
        check(v[16] ? "R5 write port" : "R2 read port", 32'(req_valid_o), 32'(exp_v));
        check(v[16] ? "R5 write kind" : "R2 read kind", 32'(req_write_o), 32'(v[16]));
        check("R6 address", 32'(req_addr_o), 32'(v[15:0]));
        if (v[16]) check("R5 write data", 32'(req_wdata_o), 32'h0);
        check("R7 done low mid-run", 32'(done_o), 32'h0);
        req_ready_i = '1;
        @(posedge clk); @(negedge clk);
        req_ready_i = '0;
        check("R4 no request while outstanding", 32'(req_valid_o), 32'h0);
        respond(port, v[15:0]);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : stim
        do_reset();
        // R1 reset state
        check("R1 valid after reset", 32'(req_valid_o), 32'h1);
        check("R1 kind after reset", 32'(req_write_o), 32'h0);
        check("R1 addr after reset", 32'(req_addr_o), 32'h0);
        check("R1 done after reset", 32'(done_o), 32'h0);
        check("R1 err after reset", 32'(err_o), 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            walk_entry(VEC[i]);
        end
        check("R7 done after target", 32'(done_o), 32'h1);
        check("R7 no request after target", 32'(req_valid_o), 32'h0);
        check("R10 no error in clean run", 32'(err_o), 32'h0);
        req_ready_i = '1;
        repeat (3) begin
            @(posedge clk); @(negedge clk);
            check("R7 stays quiet with ready high", 32'(req_valid_o), 32'h0);
        end
        req_ready_i = '0;

        // R9: response while nothing outstanding
        do_reset();
        respond(2, 16'h0000);
        check("R9 stray response sets err", 32'(err_o), 32'h1);
        check("R9 stray response ignored", 32'(req_valid_o), 32'h1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 err sticky", 32'(err_o), 32'h1);
        do_reset();
        check("R1 reset clears err", 32'(err_o), 32'h0);

        // R8: response from the wrong port
        req_ready_i = '1;
        @(posedge clk); @(negedge clk);
        req_ready_i = '0;
        respond(1, 16'h0000);
        check("R8 wrong port sets err", 32'(err_o), 32'h1);
        check("R8 wrong port no advance", 32'(req_valid_o), 32'h0);
        respond(0, 16'h0000);
        check("R8 correct response then advances", 32'(req_valid_o), 32'h2);

        // R8: right port, wrong address
        do_reset();
        req_ready_i = '1;
        @(posedge clk); @(negedge clk);
        req_ready_i = '0;
        respond(0, 16'h0040);
        check("R8 wrong address sets err", 32'(err_o), 32'h1);
        check("R8 wrong address no advance", 32'(req_valid_o), 32'h0);
        respond(0, 16'h0000);
        check("R8 next read from port 1", 32'(req_valid_o), 32'h2);
        check("R8 address unchanged", 32'(req_addr_o), 32'h0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule